// File: doc/BRIEF.md
# Single-Slot Read Response Buffer

This block keeps one response slot for outbound non-posted requests that a bridge sends to a downstream parallel bus. When a request is issued it claims the slot. For a read, the slot then gathers the returned data in fixed-size beats until the requested byte count is covered. For a non-posted write, it waits for a completion status and stores no data. Once the response is complete, the block tells the upstream link side, which sends it and then strobes the block to free the slot.

Only one request can be outstanding at a time, so the request-issue port sees back-pressure while the slot is held. The byte length is converted to a beat count using the beat size. The stored data is shown as one flat vector, with beat 0 in the least significant bits. Stray data beats and stray completions do not disturb the slot. They are dropped and reported with a one-cycle error pulse.

Top module: `resp_slot_buffer`

## Requirements
- R1: After reset, req_ready is 1, busy is 0, rsp_ready is 0, rsp_is_write is 0, proto_err is 0 and rsp_data is all zero.
- R2: A cycle with req_valid=1 and req_ready=1 claims the slot: from the next cycle busy is 1 and req_ready is 0. A req_valid while busy is 1 has no effect on the held request's kind or length.
- R3: For a read slot (req_kind=0), accepted beats are stored in arrival order, and beat k occupies rsp_data[64k+63:64k]. Every beat position not written since the slot was claimed reads as zero.
- R4: req_len is a byte count. The read response becomes ready after ceil(req_len/8) beats. A req_len of 0, or any value above 64, is treated as 64 bytes (8 beats). rsp_ready rises in the cycle after the final beat is accepted and is 0 before that.
- R5: A non-posted write (req_kind=1) holds the slot without storing data. rsp_ready rises in the cycle after wcpl_valid, and rsp_data stays all zero.
- R6: While rsp_ready is 1 it stays 1 until rsp_sent. rsp_sent with rsp_ready=1 gives busy=0, rsp_ready=0 and req_ready=1 in the next cycle. rsp_sent with rsp_ready=0 is ignored.
- R7: A beat arriving when the slot is not collecting read data (idle, write slot, or response already complete) is discarded. The same applies to a wcpl_valid when the slot is not waiting for a write completion. Either case makes proto_err 1 for exactly the next cycle and leaves rsp_data unchanged.
- R8: While busy, rsp_is_write equals the kind of the request holding the slot (1 = non-posted write). It is 0 while idle.
- R9: Capacity is 64 bytes (8 beats of 8 bytes). A 64-byte read fills all 8 positions. A further beat is rejected and overwrites nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Non-posted request issued downstream |
| req_kind | input | 1 | 0 = read, 1 = non-posted write |
| req_len | input | 7 | Requested byte count (0 or above 64 means 64) |
| req_ready | output | 1 | Slot is free and a request may be issued |
| beat_valid | input | 1 | Returned data beat present |
| beat_data | input | 64 | Returned data beat |
| wcpl_valid | input | 1 | Completion status for a non-posted write |
| rsp_sent | input | 1 | Upstream has issued the response |
| busy | output | 1 | Slot is occupied |
| rsp_ready | output | 1 | Full response is ready for upstream |
| rsp_is_write | output | 1 | Held request is a non-posted write |
| rsp_data | output | 512 | Stored data, beat 0 in the low bits |
| proto_err | output | 1 | One-cycle pulse for a discarded beat or completion |

## Verification
The bench uses the default parameters: 64 bytes of capacity in 8-byte beats, which gives eight beat positions and a 7-bit length field. With these values one 7-bit length reaches every case of interest: a single beat, a partial last beat, exactly full, zero, and values well above capacity. It therefore covers the clamp to 64 bytes and the ninth-beat overflow attempt. The short beat count also lets each table entry check rsp_ready at every intermediate beat and the whole 512-bit data image against a zero-padded model.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE     = 2'd0,
    SLOT_FILL     = 2'd1,
    SLOT_WAIT_CPL = 2'd2,
    SLOT_DONE     = 2'd3
  } slot_state_e;

  typedef enum logic {
    KIND_READ    = 1'b0,
    KIND_NPWRITE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/rsb_rst_sync.sv
module rsb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rsb_slot_ctrl.sv
module rsb_slot_ctrl
  import rsb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_kind,
  input  logic        beat_valid,
  input  logic        wcpl_valid,
  input  logic        rsp_sent,
  input  logic        fill_last,
  output logic        alloc,
  output logic        beat_accept,
  output slot_state_e state,
  output logic        kind_write,
  output logic        proto_err
);
  slot_state_e state_q, state_d;
  req_kind_e   kind_q;
  logic        err_q, err_d;

  assign alloc       = req_valid && (state_q == SLOT_IDLE);
  assign beat_accept = beat_valid && (state_q == SLOT_FILL);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SLOT_IDLE:     if (req_valid)
                       state_d = (req_kind == KIND_NPWRITE) ? SLOT_WAIT_CPL : SLOT_FILL;
      SLOT_FILL:     if (beat_accept && fill_last) state_d = SLOT_DONE;
      SLOT_WAIT_CPL: if (wcpl_valid) state_d = SLOT_DONE;
      SLOT_DONE:     if (rsp_sent) state_d = SLOT_IDLE;
      default:       state_d = SLOT_IDLE;
    endcase
  end

  always_comb begin
    err_d = (beat_valid && (state_q != SLOT_FILL)) ||
            (wcpl_valid && (state_q != SLOT_WAIT_CPL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     kind_q <= KIND_READ;
    else if (alloc) kind_q <= req_kind_e'(req_kind);
  end

  assign state      = state_q;
  assign kind_write = (kind_q == KIND_NPWRITE);
  assign proto_err  = err_q;

  assert_alloc_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (state_q != SLOT_IDLE));
  assert_kind_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != SLOT_IDLE) && req_valid) |=> $stable(kind_q));
  assert_write_cpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SLOT_WAIT_CPL) && wcpl_valid) |=> (state_q == SLOT_DONE));
  assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SLOT_DONE) && rsp_sent) |=> (state_q == SLOT_IDLE));
  assert_done_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SLOT_DONE) && !rsp_sent) |=> (state_q == SLOT_DONE));
  assert_stray_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && (state_q != SLOT_FILL)) |=> proto_err);
endmodule

// File: rtl/rsb_fill_tracker.sv
module rsb_fill_tracker #(
  parameter int CAP_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           alloc,
  input  logic [$clog2(CAP_BYTES):0]                     req_len,
  input  logic                                           beat_accept,
  output logic                                           fill_last,
  output logic [$clog2(CAP_BYTES/BEAT_BYTES)-1:0]        beat_idx
);
  localparam int LEN_W   = $clog2(CAP_BYTES) + 1;
  localparam int NBEATS  = CAP_BYTES / BEAT_BYTES;
  localparam int IDX_W   = $clog2(NBEATS);
  localparam int BEAT_SH = $clog2(BEAT_BYTES);
  localparam logic [LEN_W-1:0] CAP_L  = LEN_W'(CAP_BYTES);
  localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);

  logic [LEN_W-1:0] fill_q, fill_d;
  logic [LEN_W-1:0] target_q, target_d;
  logic [LEN_W-1:0] len_clamped;
  logic [LEN_W-1:0] fill_shifted;
  logic [LEN_W:0]   fill_after;
  logic             cnt_en;

  always_comb begin
    if ((req_len == '0) || (req_len > CAP_L)) len_clamped = CAP_L;
    else                                      len_clamped = req_len;
  end

  assign cnt_en = alloc || beat_accept;

  always_comb begin
    fill_d   = fill_q;
    target_d = target_q;
    if (alloc) begin
      fill_d   = '0;
      target_d = len_clamped;
    end else if (beat_accept) begin
      fill_d = fill_q + BEAT_L;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q   <= '0;
      target_q <= CAP_L;
    end else if (cnt_en) begin
      fill_q   <= fill_d;
      target_q <= target_d;
    end
  end

  assign fill_after   = {1'b0, fill_q} + {1'b0, BEAT_L};
  assign fill_last    = (fill_after >= {1'b0, target_q});
  assign fill_shifted = fill_q >> BEAT_SH;
  assign beat_idx     = fill_shifted[IDX_W-1:0];

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CAP_L);
  assert_target_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q != '0) && (target_q <= CAP_L));
endmodule

// File: rtl/rsb_beat_store.sv
module rsb_beat_store #(
  parameter int CAP_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    alloc,
  input  logic                                    beat_accept,
  input  logic [$clog2(CAP_BYTES/BEAT_BYTES)-1:0] beat_idx,
  input  logic [BEAT_BYTES*8-1:0]                 beat_data,
  output logic [CAP_BYTES*8-1:0]                  rsp_data
);
  localparam int NBEATS = CAP_BYTES / BEAT_BYTES;
  localparam int DW     = BEAT_BYTES * 8;
  localparam int IDX_W  = $clog2(NBEATS);

  for (genvar g = 0; g < NBEATS; g++) begin : g_word
    logic          wr_en;
    logic [DW-1:0] word_q, word_d;

    assign wr_en  = alloc || (beat_accept && (beat_idx == IDX_W'(g)));
    assign word_d = alloc ? '0 : beat_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (wr_en) word_q <= word_d;
    end

    assign rsp_data[g*DW +: DW] = word_q;
  end

  assert_store_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && !beat_accept) |=> $stable(rsp_data));
endmodule

// File: rtl/resp_slot_buffer.sv
module resp_slot_buffer
  import rsb_pkg::*;
#(
  parameter int CAP_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_kind,
  input  logic [$clog2(CAP_BYTES):0]    req_len,
  output logic                          req_ready,
  input  logic                          beat_valid,
  input  logic [BEAT_BYTES*8-1:0]       beat_data,
  input  logic                          wcpl_valid,
  input  logic                          rsp_sent,
  output logic                          busy,
  output logic                          rsp_ready,
  output logic                          rsp_is_write,
  output logic [CAP_BYTES*8-1:0]        rsp_data,
  output logic                          proto_err
);
  localparam int NBEATS = CAP_BYTES / BEAT_BYTES;
  localparam int IDX_W  = $clog2(NBEATS);

  logic              rst_n_sync;
  logic              alloc, beat_accept, fill_last, kind_write;
  logic [IDX_W-1:0]  beat_idx;
  slot_state_e       state;

  rsb_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  rsb_slot_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .beat_valid  (beat_valid),
    .wcpl_valid  (wcpl_valid),
    .rsp_sent    (rsp_sent),
    .fill_last   (fill_last),
    .alloc       (alloc),
    .beat_accept (beat_accept),
    .state       (state),
    .kind_write  (kind_write),
    .proto_err   (proto_err)
  );

  rsb_fill_tracker #(.CAP_BYTES(CAP_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .alloc       (alloc),
    .req_len     (req_len),
    .beat_accept (beat_accept),
    .fill_last   (fill_last),
    .beat_idx    (beat_idx)
  );

  rsb_beat_store #(.CAP_BYTES(CAP_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .alloc       (alloc),
    .beat_accept (beat_accept),
    .beat_idx    (beat_idx),
    .beat_data   (beat_data),
    .rsp_data    (rsp_data)
  );

  assign req_ready    = (state == SLOT_IDLE);
  assign busy         = (state != SLOT_IDLE);
  assign rsp_ready    = (state == SLOT_DONE);
  assign rsp_is_write = busy && kind_write;

  assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(req_ready && rsp_ready));
  assert_free_after_sent_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rsp_ready && rsp_sent) |=> req_ready);
  assert_write_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rsp_is_write |-> (rsp_data == '0));
endmodule

// File: tb/resp_slot_buffer_test.sv
`timescale 1ns/1ps
module resp_slot_buffer_test;
  localparam int CAP = 64;
  localparam int BB  = 8;
  localparam int DW  = CAP * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_kind;
  logic [6:0]    req_len;
  logic          req_ready;
  logic          beat_valid;
  logic [63:0]   beat_data;
  logic          wcpl_valid, rsp_sent;
  logic          busy, rsp_ready, rsp_is_write, proto_err;
  logic [DW-1:0] rsp_data;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  resp_slot_buffer #(.CAP_BYTES(CAP), .BEAT_BYTES(BB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_len(req_len), .req_ready(req_ready), .beat_valid(beat_valid),
    .beat_data(beat_data), .wcpl_valid(wcpl_valid), .rsp_sent(rsp_sent),
    .busy(busy), .rsp_ready(rsp_ready), .rsp_is_write(rsp_is_write),
    .rsp_data(rsp_data), .proto_err(proto_err)
  );

  // {kind, len[6:0], expected beats[3:0]}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 7'd64,  4'd8},
    {1'b0, 7'd8,   4'd1},
    {1'b0, 7'd20,  4'd3},
    {1'b0, 7'd0,   4'd8},
    {1'b0, 7'd100, 4'd8},
    {1'b1, 7'd32,  4'd0},
    {1'b0, 7'd57,  4'd8},
    {1'b0, 7'd16,  4'd2}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] pat(input int v, input int k);
    return {32'hC0DE0000 + 32'(v), 32'h00A50000 + 32'(k)};
  endfunction

  task automatic issue(input logic kind, input logic [6:0] len);
    req_valid = 1'b1; req_kind = kind; req_len = len;
    step();
    req_valid = 1'b0;
  endtask

  task automatic send_beat(input logic [63:0] d);
    beat_valid = 1'b1; beat_data = d;
    step();
    beat_valid = 1'b0;
  endtask

  task automatic pulse_cpl();
    wcpl_valid = 1'b1; step(); wcpl_valid = 1'b0;
  endtask

  task automatic pulse_sent();
    rsp_sent = 1'b1; step(); rsp_sent = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_img;
    logic [DW-1:0] held;
    rst_n = 1'b0; req_valid = 0; req_kind = 0; req_len = '0;
    beat_valid = 0; beat_data = '0; wcpl_valid = 0; rsp_sent = 0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 req_ready", DW'(req_ready), DW'(1));
    chk("R1 busy", DW'(busy), '0);
    chk("R1 rsp_ready", DW'(rsp_ready), '0);
    chk("R1 rsp_is_write", DW'(rsp_is_write), '0);
    chk("R1 proto_err", DW'(proto_err), '0);
    chk("R1 rsp_data", rsp_data, '0);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      logic       kind;
      logic [6:0] len;
      int         nb;
      kind = VEC[i][11]; len = VEC[i][10:4]; nb = int'(VEC[i][3:0]);
      exp_img = '0;
      issue(kind, len);
      chk($sformatf("R2 busy v%0d", i), DW'(busy), DW'(1));
      chk($sformatf("R2 req_ready v%0d", i), DW'(req_ready), '0);
      chk($sformatf("R8 kind v%0d", i), DW'(rsp_is_write), DW'(kind));
      if (kind) begin
        chk($sformatf("R5 not ready before cpl v%0d", i), DW'(rsp_ready), '0);
        pulse_cpl();
      end else begin
        for (int k = 0; k < nb; k++) begin
          chk($sformatf("R4 not ready before beat %0d v%0d", k, i), DW'(rsp_ready), '0);
          exp_img[k*64 +: 64] = pat(i, k);
          send_beat(pat(i, k));
        end
      end
      chk($sformatf("R4 ready v%0d", i), DW'(rsp_ready), DW'(1));
      chk($sformatf("R3 data v%0d", i), rsp_data, exp_img);
      chk($sformatf("R8 kind at ready v%0d", i), DW'(rsp_is_write), DW'(kind));
      step();
      chk($sformatf("R6 ready held v%0d", i), DW'(rsp_ready), DW'(1));
      pulse_sent();
      chk($sformatf("R6 freed v%0d", i), DW'({req_ready, busy, rsp_ready}), DW'(3'b100));
    end

    // R7 beat with no slot
    held = rsp_data;
    send_beat(64'hDEAD_BEEF_0000_0001);
    chk("R7 err after stray beat", DW'(proto_err), DW'(1));
    chk("R7 data untouched", rsp_data, held);
    chk("R7 still idle", DW'(busy), '0);
    step();
    chk("R7 err one cycle", DW'(proto_err), '0);

    // R6 sent without ready ignored
    pulse_sent();
    chk("R6 stray sent ignored", DW'({req_ready, busy}), DW'(2'b10));

    // R2 second request while busy ignored
    issue(1'b0, 7'd16);
    issue(1'b1, 7'd8);
    chk("R2 kind kept", DW'(rsp_is_write), '0);
    send_beat(pat(50, 0));
    chk("R2 length kept", DW'(rsp_ready), '0);
    send_beat(pat(50, 1));
    chk("R4 two beats ready", DW'(rsp_ready), DW'(1));
    held = rsp_data;
    pulse_cpl();
    chk("R7 stray cpl err", DW'(proto_err), DW'(1));
    chk("R7 stray cpl keeps ready", DW'(rsp_ready), DW'(1));
    pulse_sent();

    // R5 / R7 beat aimed at a write slot
    issue(1'b1, 7'd40);
    send_beat(64'h1111_2222_3333_4444);
    chk("R7 beat on write slot err", DW'(proto_err), DW'(1));
    chk("R5 no data stored", rsp_data, '0);
    chk("R5 not ready yet", DW'(rsp_ready), '0);
    pulse_cpl();
    chk("R5 ready after cpl", DW'(rsp_ready), DW'(1));
    chk("R8 write flagged", DW'(rsp_is_write), DW'(1));
    pulse_sent();
    chk("R8 idle clears kind", DW'(rsp_is_write), '0);

    // R9 full capacity then overflow beat
    issue(1'b0, 7'd64);
    exp_img = '0;
    for (int k = 0; k < 8; k++) begin
      exp_img[k*64 +: 64] = pat(77, k);
      send_beat(pat(77, k));
    end
    chk("R9 full data", rsp_data, exp_img);
    send_beat(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 overflow err", DW'(proto_err), DW'(1));
    chk("R9 overflow no overwrite", rsp_data, exp_img);
    pulse_sent();
    chk("R6 final free", DW'(req_ready), DW'(1));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule